// File: doc/BRIEF.md
# Reset-Triggered Identification Stream Shifter

This block answers a card-style synchronous reset with a fixed identification word. A host selects the block, raises the reset line and gives one pulse on the serial clock. The block then places the word on a single serial data output, one bit per serial clock pulse, least significant bit first. Once the last bit has been presented it releases the line by dropping its output enable. The word and its width are parameters.

The serial clock, select and reset lines are sampled by the block's own system clock. The block acts on edges of the serial clock that it detects in those samples. Both outputs come from registers: a sampled input edge shows at the outputs one system clock cycle after the system clock edge that sees it. Dropping the select line at any moment abandons the stream. Analog timing limits and pull-up behaviour are not modelled.

Top module: `reset_answer_shifter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `card_dout_oe` and `card_dout` are 0.
- R2: A rising serial clock edge seen while `card_sel` and `card_rst` are both high arms the block. `card_dout_oe` stays 0 until the falling edge of that same pulse.
- R3: The falling edge of the arming pulse sets `card_dout_oe` to 1 and presents bit 0 of `ID_WORD`. Each later falling edge moves on one bit, going up through bit `W-1`, so the least significant bit comes first.
- R4: While the output is enabled, `card_dout` changes only after a falling serial clock edge. A rising edge with `card_rst` low leaves the bit in place.
- R5: The falling edge after the one that presented bit `W-1` drops `card_dout_oe` to 0, which releases the line.
- R6: After the release, serial clock pulses with `card_rst` low keep `card_dout_oe` at 0. Only a new arming pulse (R2) starts the stream again, and it starts from bit 0.
- R7: `card_sel` low forces `card_dout_oe` to 0 one cycle later. Serial clock pulses seen while `card_sel` is low do not arm the block, whatever the level of `card_rst`.
- R8: A new arming pulse in the middle of a stream drops `card_dout_oe` at its rising edge. The stream then restarts at bit 0 on that pulse's falling edge.
- R9: `card_dout` is 0 whenever `card_dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous block reset |
| card_sel | input | 1 | Active-high select; low abandons any stream |
| card_rst | input | 1 | Card reset line; high on a rising serial clock edge arms the block |
| card_clk | input | 1 | Serial clock, sampled by `clk` |
| card_dout | output | 1 | Serial data bit, 0 when not enabled |
| card_dout_oe | output | 1 | Output enable for the data line; 0 means high impedance |

## Verification
The bench builds the block with `W` = 32 and an uneven `ID_WORD` of 32'h1E0F_A5C3. With this word, reversed order, a bit shifted by one place or a stuck bit gives a different captured word. Because the word is the full width, the counter's last value and the release after bit 31 are both reached, so the release and the ignored pulses that follow can be checked. Every stream is also compared, cycle by cycle, with a behavioural model. The runs include a restart in the middle of a stream and an abort in the middle of a stream, so the bits after a restart must begin again at bit 0.

// File: rtl/reset_answer_shifter.sv
module reset_answer_shifter #(
  parameter int W = 32,
  parameter logic [W-1:0] ID_WORD = 32'h1E0F_A5C3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_sel,
  input  logic card_rst,
  input  logic card_clk,
  output logic card_dout,
  output logic card_dout_oe
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SHIFT, ST_DONE} st_t;

  st_t           state_q;
  logic [CW-1:0] cnt_q;
  logic          clk_q;
  logic          clk_rise, clk_fall;

  assign clk_rise = card_clk & ~clk_q;
  assign clk_fall = ~card_clk & clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      clk_q   <= 1'b0;
    end else begin
      clk_q <= card_clk;
      if (!card_sel) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (clk_rise && card_rst) begin
        state_q <= ST_ARMED;
        cnt_q   <= '0;
      end else if (clk_fall) begin
        case (state_q)
          ST_ARMED: state_q <= ST_SHIFT;
          ST_SHIFT: begin
            if (cnt_q == LAST) begin
              state_q <= ST_DONE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign card_dout_oe = (state_q == ST_SHIFT);
  assign card_dout    = card_dout_oe & ID_WORD[cnt_q];

  assert_arm_keeps_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && card_rst && card_sel) |=> !card_dout_oe);

  assert_enable_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_dout_oe) |-> $past(clk_fall));

  assert_hold_between_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (card_dout_oe && $past(card_dout_oe) && !$past(clk_fall)) |-> $stable(card_dout));

  assert_release_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_dout_oe) && $past(card_sel)) |->
      ($past(clk_fall && cnt_q == LAST) || $past(clk_rise && card_rst)));

  assert_deselect_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !card_sel |=> !card_dout_oe);

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !card_dout_oe |-> !card_dout);
endmodule

// File: tb/reset_answer_shifter_tb.sv
`timescale 1ns/1ps
module reset_answer_shifter_tb;
  localparam int W = 32;
  localparam logic [W-1:0] PAT = 32'h1E0F_A5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic card_sel = 1'b0, card_rst = 1'b0, card_clk = 1'b0;
  logic card_dout, card_dout_oe;
  int checks = 0, errors = 0;
  bit  model_on = 0;

  always #2.5 clk = ~clk;

  reset_answer_shifter #(.W(W), .ID_WORD(PAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .card_sel(card_sel), .card_rst(card_rst),
    .card_clk(card_clk), .card_dout(card_dout), .card_dout_oe(card_dout_oe));

  // behavioural model: pos -1 = line released, -2 = armed, 0..W-1 = bit shown
  int   m_pos = -1;
  logic m_prev = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = -1; m_prev = 1'b0;
    end else begin
      if (!card_sel) m_pos = -1;
      else if (card_clk && !m_prev && card_rst) m_pos = -2;
      else if (!card_clk && m_prev) begin
        if (m_pos == -2) m_pos = 0;
        else if (m_pos >= 0) m_pos = (m_pos == W - 1) ? -1 : m_pos + 1;
      end
      m_prev = card_clk;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    check("R3/R5 oe vs model", card_dout_oe, logic'(m_pos >= 0));
    check("R3/R9 dout vs model", card_dout, (m_pos >= 0) ? PAT[m_pos] : 1'b0);
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rise_edge(); card_clk = 1'b1; wait_n(2); endtask
  task automatic fall_edge(); card_clk = 1'b0; wait_n(2); endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    wait_n(3);
    check("R1 oe in reset", card_dout_oe, 1'b0);
    check("R1 dout in reset", card_dout, 1'b0);
    rst_n = 1'b1;
    wait_n(1);
    check("R1 oe after reset", card_dout_oe, 1'b0);
    model_on = 1;

    // full stream
    card_sel = 1'b1; card_rst = 1'b1; wait_n(1);
    rise_edge();
    check("R2 armed but silent", card_dout_oe, 1'b0);
    card_rst = 1'b0;
    fall_edge();
    check("R3 enabled after first fall", card_dout_oe, 1'b1);
    got = '0;
    for (int b = 0; b < W; b++) begin
      got[b] = card_dout;
      if (b < W - 1) begin
        rise_edge();
        check("R4 bit held over rise", card_dout, PAT[b]);
        fall_edge();
      end
    end
    checks++;
    if (got !== PAT) begin
      errors++;
      $display("FAIL R3 word: actual %h expected %h", got, PAT);
    end
    rise_edge(); fall_edge();
    check("R5 released after last bit", card_dout_oe, 1'b0);
    check("R9 dout low when released", card_dout, 1'b0);
    for (int k = 0; k < 3; k++) begin rise_edge(); fall_edge(); end
    check("R6 extra pulses ignored", card_dout_oe, 1'b0);

    // new sequence, then restart mid-stream
    card_rst = 1'b1; rise_edge(); card_rst = 1'b0; fall_edge();
    check("R6 new sequence bit0", card_dout, PAT[0]);
    for (int k = 0; k < 5; k++) begin rise_edge(); fall_edge(); end
    check("R3 sixth bit", card_dout, PAT[5]);
    card_rst = 1'b1; rise_edge();
    check("R8 restart silences", card_dout_oe, 1'b0);
    card_rst = 1'b0; fall_edge();
    check("R8 restart oe", card_dout_oe, 1'b1);
    check("R8 restart bit0", card_dout, PAT[0]);
    rise_edge(); fall_edge();
    check("R8 restart bit1", card_dout, PAT[1]);

    // abort by deselect
    card_sel = 1'b0; wait_n(1);
    check("R7 deselect releases", card_dout_oe, 1'b0);
    card_rst = 1'b1;
    rise_edge(); fall_edge();
    check("R7 pulse while deselected ignored", card_dout_oe, 1'b0);
    card_rst = 1'b0;
    card_sel = 1'b1; wait_n(1);
    rise_edge(); fall_edge();
    check("R7 no arm without reset line", card_dout_oe, 1'b0);
    card_rst = 1'b1; rise_edge(); card_rst = 1'b0; fall_edge();
    check("R7 rearm after reselect", card_dout, PAT[0]);
    check("R7 rearm oe", card_dout_oe, 1'b1);
    wait_n(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule